// File: doc/BRIEF.md
# Bucketed Message Receive Unit

This block sits between a message ring and one processor core. Arriving messages are sorted into eight per-core receive buckets. Each bucket is a small FIFO with its own capacity limit. Software pulls a message by issuing a load command that names one bucket. The unit then shows a load-pending flag in its status word for one cycle. After that it either moves the oldest message of that bucket into a four-word receive buffer, or it reports an error because the bucket was empty.

The status word carries the metadata of the last good load: length, code and sender station. The receive error field tells whether the buffer contents are valid. The receive buffer words are read combinationally through a word index. Each time a message leaves a bucket, the unit pulses a credit return addressed to the station that sent it. The ring side is flow-controlled through a ready signal: a message bound for a full bucket is held back by the sender and is never lost. A mask output shows which buckets currently hold at least one message.

Top module: `msg_rx_unit`

## Requirements
- R1: After reset the status word is zero, `wait_mask` is zero, and every bucket size equals MAXD, so `in_ready` is high.
- R2: `in_ready` is high exactly when the bucket named by `in_bucket` holds fewer messages than its configured size. A message is stored only when `in_valid` and `in_ready` are both high in the same cycle. Messages leave each bucket in arrival order.
- R3: A `ld_req` accepted while no load is pending sets status bit 3 in the next cycle. The bit clears one cycle later. A `ld_req` seen while bit 3 is set is ignored.
- R4: A load from a non-empty bucket sets status bits 5:4 to 0. It writes the message length minus one into bits 7:6, the code into bits 15:8 and the sender station into bits 22:16. `rd_word` for index i then returns bits 64*i+63 down to 64*i of the message payload.
- R5: A load from an empty bucket sets status bits 5:4 to 2'b01. It leaves bits 22:6 and the receive buffer unchanged.
- R6: Every good load produces a one-cycle `cr_valid` pulse, with `cr_station` equal to the message's sender. The pulse comes in the same cycle that the status fields update. No pulse is produced otherwise.
- R7: Bit b of `wait_mask` is high exactly when bucket b holds at least one message.
- R8: A write with `cfg_we` sets the size of bucket `cfg_bucket`. Values above MAXD are clamped to MAXD. A size of 0 blocks all arrivals to that bucket. Lowering a size below the current fill discards no stored message.
- R9: Status bits 2:0 and 31:23 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Arriving message present |
| in_bucket | input | 3 | Target bucket of the arriving message |
| in_len | input | 2 | Message length minus one |
| in_code | input | 8 | Message code |
| in_src | input | 7 | Sender station ID |
| in_data | input | 256 | Message payload, four 64-bit words |
| in_ready | output | 1 | Target bucket has room |
| ld_req | input | 1 | Load command |
| ld_bucket | input | 3 | Bucket selected by the load |
| status | output | 32 | Status word |
| rd_idx | input | 2 | Receive buffer word index |
| rd_word | output | 64 | Selected receive buffer word |
| cfg_we | input | 1 | Bucket size write strobe |
| cfg_bucket | input | 3 | Bucket whose size is written |
| cfg_size | input | 3 | New bucket size |
| wait_mask | output | 8 | Non-empty flag per bucket |
| cr_valid | output | 1 | Credit return pulse |
| cr_station | output | 7 | Station that receives the credit |

## Verification
The assertions assume synchronous inputs that are sampled only at the rising edge. They also assume that the sender never counts a message as delivered unless `in_ready` was high in that cycle. The bench drives every input on the falling edge. It keeps a bucket-level queue model that accepts exactly when the model's fill is below its size, so the design's flow control is never bypassed. Load commands are issued freely, including while a load is pending, because the design must ignore those.

// File: rtl/msg_rx_unit.sv
module msg_rx_unit #(
  parameter int MAXD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   in_bucket,
  input  logic [1:0]   in_len,
  input  logic [7:0]   in_code,
  input  logic [6:0]   in_src,
  input  logic [255:0] in_data,
  output logic         in_ready,
  input  logic         ld_req,
  input  logic [2:0]   ld_bucket,
  output logic [31:0]  status,
  input  logic [1:0]   rd_idx,
  output logic [63:0]  rd_word,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_bucket,
  input  logic [2:0]   cfg_size,
  output logic [7:0]   wait_mask,
  output logic         cr_valid,
  output logic [6:0]   cr_station
);
  localparam int NB    = 8;
  localparam int PW    = $clog2(MAXD);
  localparam int CW    = $clog2(MAXD + 1);
  localparam int MW    = 17;

  logic [255:0]  mem_d [NB][MAXD];
  logic [MW-1:0] mem_m [NB][MAXD];
  logic [PW-1:0] wp [NB];
  logic [PW-1:0] rp [NB];
  logic [CW-1:0] cnt [NB];
  logic [CW-1:0] lim [NB];

  logic          pend;
  logic [2:0]    sel;
  logic [1:0]    err;
  logic [MW-1:0] meta;
  logic [255:0]  rbuf;

  logic push, pop;
  logic [MW-1:0] head_m;

  assign in_ready = {{(32-CW){1'b0}}, cnt[in_bucket]} < {{(32-CW){1'b0}}, lim[in_bucket]};
  assign push     = in_valid && in_ready;
  assign pop      = pend && (cnt[sel] != '0);
  assign head_m   = mem_m[sel][rp[sel]];
  assign status   = {9'd0, meta[6:0], meta[14:7], meta[16:15], err, pend, 3'd0};
  assign rd_word  = rbuf[rd_idx*64 +: 64];

  always_comb
    for (int b = 0; b < NB; b++) wait_mask[b] = (cnt[b] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      sel        <= '0;
      err        <= '0;
      meta       <= '0;
      rbuf       <= '0;
      cr_valid   <= 1'b0;
      cr_station <= '0;
      for (int b = 0; b < NB; b++) begin
        wp[b]  <= '0;
        rp[b]  <= '0;
        cnt[b] <= '0;
        lim[b] <= CW'(MAXD);
      end
    end else begin
      cr_valid <= pop;
      if (!pend) begin
        if (ld_req) begin
          pend <= 1'b1;
          sel  <= ld_bucket;
        end
      end else begin
        pend <= 1'b0;
        if (pop) begin
          err        <= 2'b00;
          meta       <= head_m;
          rbuf       <= mem_d[sel][rp[sel]];
          cr_station <= head_m[6:0];
          rp[sel]    <= rp[sel] + 1'b1;
        end else begin
          err <= 2'b01;
        end
      end
      if (push) begin
        mem_d[in_bucket][wp[in_bucket]] <= in_data;
        mem_m[in_bucket][wp[in_bucket]] <= {in_len, in_code, in_src};
        wp[in_bucket] <= wp[in_bucket] + 1'b1;
      end
      for (int b = 0; b < NB; b++)
        cnt[b] <= cnt[b] + CW'(push && in_bucket == 3'(b)) - CW'(pop && sel == 3'(b));
      if (cfg_we)
        lim[cfg_bucket] <= (32'(cfg_size) > MAXD) ? CW'(MAXD) : CW'(cfg_size);
    end
  end
endmodule

// File: rtl/msg_rx_unit_chk.sv
module msg_rx_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  in_bucket,
  input logic        in_ready,
  input logic [31:0] status,
  input logic [7:0]  wait_mask,
  input logic        cr_valid
);
  AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) status[3] |=> !status[3]); // R3
  AST_CREDIT_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n) cr_valid |-> $past(status[3])); // R6
  AST_CREDIT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) cr_valid |-> status[5:4] == 2'b00); // R4
  AST_EMPTY_ERR: assert property (@(posedge clk) disable iff (!rst_n) ($fell(status[3]) && !cr_valid) |-> status[5:4] == 2'b01); // R5
  AST_PUSH_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> wait_mask[$past(in_bucket)]); // R7
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n) status[2:0] == 3'd0 && status[31:23] == 9'd0); // R9
endmodule

bind msg_rx_unit msg_rx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bucket(in_bucket),
  .in_ready(in_ready), .status(status), .wait_mask(wait_mask), .cr_valid(cr_valid)
);

// File: tb/msg_rx_unit_tb.sv
module msg_rx_unit_tb;
  localparam int MAXD = 4;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0; logic [2:0] in_bucket = 0; logic [1:0] in_len = 0;
  logic [7:0] in_code = 0; logic [6:0] in_src = 0; logic [255:0] in_data = 0;
  logic in_ready, ld_req = 0; logic [2:0] ld_bucket = 0;
  logic [31:0] status; logic [1:0] rd_idx = 0; logic [63:0] rd_word;
  logic cfg_we = 0; logic [2:0] cfg_bucket = 0, cfg_size = 0;
  logic [7:0] wait_mask; logic cr_valid; logic [6:0] cr_station;

  always #4 clk = ~clk;

  msg_rx_unit #(.MAXD(MAXD)) u_dut (.*);

  logic [255:0] qd [8][$];
  logic [16:0]  qm [8][$];
  int m_size [8];
  bit m_pend; int m_sel; logic [1:0] m_err; logic [16:0] m_meta; logic [255:0] m_buf;
  bit m_cr; logic [6:0] m_crst;
  int n_chk = 0, n_fail = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 8; b++) begin qd[b].delete(); qm[b].delete(); m_size[b] = MAXD; end
      m_pend = 0; m_sel = 0; m_err = 0; m_meta = 0; m_buf = 0; m_cr = 0; m_crst = 0;
    end else begin
      bit acc; bit was_pend;
      acc = in_valid && (qd[in_bucket].size() < m_size[in_bucket]);
      was_pend = m_pend;
      m_cr = 0;
      if (was_pend) begin
        m_pend = 0;
        if (qd[m_sel].size() == 0) m_err = 2'b01;
        else begin
          m_err = 0; m_buf = qd[m_sel].pop_front(); m_meta = qm[m_sel].pop_front();
          m_cr = 1; m_crst = m_meta[6:0];
        end
      end else if (ld_req) begin
        m_pend = 1; m_sel = int'(ld_bucket);
      end
      if (acc) begin qd[in_bucket].push_back(in_data); qm[in_bucket].push_back({in_len, in_code, in_src}); end
      if (cfg_we) m_size[cfg_bucket] = (int'(cfg_size) > MAXD) ? MAXD : int'(cfg_size);
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] em;
    logic [31:0] es;
    for (int b = 0; b < 8; b++) em[b] = qd[b].size() != 0;
    es = {9'd0, m_meta[6:0], m_meta[14:7], m_meta[16:15], m_err, m_pend, 3'd0};
    chk("R2 in_ready", 64'(in_ready), 64'(qd[in_bucket].size() < m_size[in_bucket]));
    chk("R3/R4/R5/R9 status", 64'(status), 64'(es));
    chk("R4/R5 rd_word", rd_word, m_buf[rd_idx*64 +: 64]);
    chk("R7 wait_mask", 64'(wait_mask), 64'(em));
    chk("R6 cr_valid", 64'(cr_valid), 64'(m_cr));
    if (m_cr) chk("R6 cr_station", 64'(cr_station), 64'(m_crst));
  endtask

  task automatic step();
    @(negedge clk); compare_all();
    in_valid = 0; ld_req = 0; cfg_we = 0;
  endtask

  task automatic send(int b, int sig);
    in_valid = 1; in_bucket = 3'(b); in_len = 2'(sig); in_code = 8'(sig * 7);
    in_src = 7'(sig + 3); in_data = {4{32'(sig), 32'hA5A5_0000 + 32'(b)}} ^ 256'(sig << 40);
  endtask

  bit wd_fired = 0;
  initial begin
    #1_000_000; wd_fired = 1; n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk); $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", 64'(status), 0); chk("R1 wait_mask", 64'(wait_mask), 0);
    chk("R1 in_ready", 64'(in_ready), 1);
    rst_n = 1;
    step();
    // R5 load from empty bucket
    ld_req = 1; ld_bucket = 2; step(); step(); step();
    // R2 fill bucket 1 to full, then an extra offer
    for (int i = 0; i < MAXD + 2; i++) begin send(1, i + 1); step(); end
    chk("R2 full bucket blocks", 64'(in_ready), 0);
    // R3 load then repeated ld_req while pending
    ld_req = 1; ld_bucket = 1; step();
    ld_req = 1; ld_bucket = 1; step(); step();
    for (int k = 0; k < 4; k++) begin rd_idx = 2'(k); step(); end
    // R8 size zero blocks, oversize clamps
    cfg_we = 1; cfg_bucket = 5; cfg_size = 0; step();
    send(5, 9); step(); step();
    chk("R8 size zero blocks", 64'(wait_mask[5]), 0);
    cfg_we = 1; cfg_bucket = 5; cfg_size = 7; step();
    for (int i = 0; i < 6; i++) begin send(5, 20 + i); step(); end
    // R8 lower size below fill keeps contents
    cfg_we = 1; cfg_bucket = 5; cfg_size = 1; step();
    for (int i = 0; i < 5; i++) begin ld_req = 1; ld_bucket = 5; step(); step(); end
    // mixed traffic
    for (int c = 0; c < 3000; c++) begin
      rd_idx = 2'($urandom);
      if ($urandom % 3 == 0) send(int'($urandom % 8), int'($urandom % 200));
      if ($urandom % 4 == 0) begin ld_req = 1; ld_bucket = 3'($urandom); end
      if ($urandom % 50 == 0) begin cfg_we = 1; cfg_bucket = 3'($urandom); cfg_size = 3'($urandom); end
      step();
    end
    if (!wd_fired) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk); $finish;
    end
  end
endmodule